// File: doc/BRIEF.md
# BIST Test-Clock Cycle Counter

This block sits inside a scan bridge. It measures how long a built-in self-test runs on a downstream scan port that has been parked. The host loads a 32-bit cycle budget through a serial data register. It then turns counting on with an instruction. From that point the counter decrements once per rising test clock. When the count reaches zero, a completion bit is set. The host polls that bit by scanning an 8-bit mode register, and turns counting off before it reconnects the downstream port.

The block follows the bridge TAP controller state, which arrives as a 4-bit code. It also takes four decoded instruction strobes and the serial data input. It returns serial data on the falling test clock. The count register and the mode register each have their own capture/shift/update path. Capturing the count register returns the live count, so a read of the count also reloads it with the bits shifted in.

Top module: `bist_cycle_counter`

## Requirements
- R1: After the asynchronous reset the count is 0, counting is off and the mode register reads 0x01, with bit 7 (the done bit) at 0.
- R2: In TAP state Capture-DR (code 0x6), the selected register captures its value: the live count when cnt_sel_i is high, or {done, mode bits 6:0} when mode_sel_i is high. In Shift-DR (code 0x2) the selected register shifts right, taking tdi_i into its MSB. The register's LSB appears on tdo_o after each falling clock edge, so the captured value leaves LSB first.
- R3: In Update-DR (code 0x5) with cnt_sel_i high, the shifted 32-bit value is loaded into the count. From the next rising edge on, while counting is on, the count drops by exactly one per rising edge and then holds at 0.
- R4: A rising edge with cnt_on_i high turns counting on. A rising edge with cnt_off_i high turns it off, and off wins when both are high. While counting is off, the count does not change except through a load.
- R5: Mode bit 7 reads 0 until the count reaches 0 by decrementing. It then reads 1 and stays 1 until the next load or reset. A load of a nonzero value clears it, and a load of 0 sets it at once.
- R6: In Update-DR with mode_sel_i high, mode bits 6:0 take the shifted bits 6:0. Bit 7 cannot be written and always reflects the done state.
- R7: tdo_o is 0 whenever the TAP state is not Shift-DR.
- R8: A rising edge in Test-Logic-Reset (code 0xF) clears the count, the done bit and the counting enable, and returns the mode register to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tap_state_i | input | 4 | Bridge TAP controller state code |
| cnt_on_i | input | 1 | Counter-on instruction active |
| cnt_off_i | input | 1 | Counter-off instruction active |
| cnt_sel_i | input | 1 | Count data register selected |
| mode_sel_i | input | 1 | Mode data register selected |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, updated on falling edge |

## Verification
The registers take new values on rising edges, so a capture, shift, load, enable change or state reset is visible from the rising edge after the cycle in which its input was applied. A decrement shows up one rising edge after a load or an enable. Each data bit reaches tdo_o half a cycle after the corresponding capture or shift edge.

The bench drives its inputs just after each rising edge and samples tdo_o just after each falling edge. Its reference model advances once per applied cycle. A capture therefore compares the shifted-out word with the model state from before that capture edge. Done timing is checked through mode reads issued after a random number of idle cycles.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int unsigned CNT_W  = 32;
  localparam int unsigned MODE_W = 8;

  typedef enum logic [3:0] {
    TS_EXIT2_DR   = 4'h0,
    TS_EXIT1_DR   = 4'h1,
    TS_SHIFT_DR   = 4'h2,
    TS_PAUSE_DR   = 4'h3,
    TS_SEL_IR     = 4'h4,
    TS_UPDATE_DR  = 4'h5,
    TS_CAPTURE_DR = 4'h6,
    TS_SEL_DR     = 4'h7,
    TS_EXIT2_IR   = 4'h8,
    TS_EXIT1_IR   = 4'h9,
    TS_SHIFT_IR   = 4'hA,
    TS_PAUSE_IR   = 4'hB,
    TS_IDLE       = 4'hC,
    TS_UPDATE_IR  = 4'hD,
    TS_CAPTURE_IR = 4'hE,
    TS_RESET      = 4'hF
  } tap_state_e;
endpackage

// File: rtl/bcc_dr_shift.sv
module bcc_dr_shift #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic         shift_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         tdi_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= RST_VAL;
    else if (clr_i)   sh_q <= RST_VAL;
    else if (cap_i)   sh_q <= cap_val_i;
    else if (shift_i) sh_q <= {tdi_i, sh_q[W-1:1]};
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/bcc_enable.sv
module bcc_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic on_i,
  input  logic off_i,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (clr_i) en_q <= 1'b0;
    else if (off_i) en_q <= 1'b0;  // off dominates
    else if (on_i)  en_q <= 1'b1;
  end

  assign en_o = en_q;
endmodule

// File: rtl/bcc_counter.sv
module bcc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         done_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         done_q;
  logic         zero;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= load_val_i;
      done_q <= (load_val_i == '0);
    end else if (en_i && !zero) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) done_q <= 1'b1;  // sticky
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/bist_cycle_counter.sv
module bist_cycle_counter
  import bcc_pkg::*;
#(
  parameter int unsigned CNT_BITS  = CNT_W,
  parameter int unsigned MODE_BITS = MODE_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] tap_state_i,
  input  logic       cnt_on_i,
  input  logic       cnt_off_i,
  input  logic       cnt_sel_i,
  input  logic       mode_sel_i,
  input  logic       tdi_i,
  output logic       tdo_o
);
  localparam int unsigned DONE_BIT = MODE_BITS - 1;
  localparam logic [DONE_BIT-1:0] MODE_RST = DONE_BIT'(1);

  logic in_tlr, in_cap, in_shift, in_upd;
  logic cnt_load, mode_load;
  logic [CNT_BITS-1:0]  cnt_q, cnt_sh;
  logic [MODE_BITS-1:0] mode_sh;
  logic [DONE_BIT-1:0]  mode_q;
  logic done_q, cnt_en;
  logic tdo_q;
  logic unused_mode_msb;

  assign in_tlr   = (tap_state_i == TS_RESET);
  assign in_cap   = (tap_state_i == TS_CAPTURE_DR);
  assign in_shift = (tap_state_i == TS_SHIFT_DR);
  assign in_upd   = (tap_state_i == TS_UPDATE_DR);

  assign cnt_load  = in_upd && cnt_sel_i;
  assign mode_load = in_upd && mode_sel_i;

  bcc_dr_shift #(.W(CNT_BITS), .RST_VAL('0)) u_cnt_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (in_tlr),
    .cap_i     (in_cap && cnt_sel_i),
    .shift_i   (in_shift && cnt_sel_i),
    .cap_val_i (cnt_q),
    .tdi_i     (tdi_i),
    .sh_o      (cnt_sh)
  );

  bcc_dr_shift #(.W(MODE_BITS), .RST_VAL({1'b0, MODE_RST})) u_mode_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (in_tlr),
    .cap_i     (in_cap && mode_sel_i),
    .shift_i   (in_shift && mode_sel_i),
    .cap_val_i ({done_q, mode_q}),
    .tdi_i     (tdi_i),
    .sh_o      (mode_sh)
  );

  // bit 7 of the mode shifter is read-only status; its update value is dropped
  assign unused_mode_msb = mode_sh[DONE_BIT];

  bcc_enable u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (in_tlr),
    .on_i   (cnt_on_i),
    .off_i  (cnt_off_i),
    .en_o   (cnt_en)
  );

  bcc_counter #(.W(CNT_BITS)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (in_tlr),
    .load_i     (cnt_load),
    .load_val_i (cnt_sh),
    .en_i       (cnt_en),
    .cnt_o      (cnt_q),
    .done_o     (done_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RST;
    else if (in_tlr)    mode_q <= MODE_RST;
    else if (mode_load) mode_q <= mode_sh[DONE_BIT-1:0];
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     tdo_q <= 1'b0;
    else if (in_shift && cnt_sel_i)  tdo_q <= cnt_sh[0];
    else if (in_shift && mode_sel_i) tdo_q <= mode_sh[0];
    else                             tdo_q <= 1'b0;
  end

  assign tdo_o = tdo_q;
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
  import bcc_pkg::*;
#(
  parameter int unsigned CNT_BITS = CNT_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [3:0]          tap_state_i,
  input logic                cnt_sel_i,
  input logic                tdo_o,
  input logic [CNT_BITS-1:0] cnt_q,
  input logic [CNT_BITS-1:0] cnt_sh,
  input logic                done_q,
  input logic                cnt_en
);
  logic load, tlr;
  assign load = (tap_state_i == TS_UPDATE_DR) && cnt_sel_i;
  assign tlr  = (tap_state_i == TS_RESET);

  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en && (cnt_q != '0) && !load && !tlr |=> cnt_q == $past(cnt_q) - CNT_BITS'(1)); // R3
  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) && !load |=> cnt_q == '0); // R3
  AST_NO_COUNT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en && !load && !tlr |=> $stable(cnt_q)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !load && !tlr |=> done_q); // R5
  AST_DONE_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> cnt_q == '0); // R5
  AST_LOAD_ZERO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load && (cnt_sh == '0) |=> done_q); // R5
  AST_TDO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_state_i != TS_SHIFT_DR |-> !tdo_o); // R7
  AST_TLR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlr |=> (cnt_q == '0) && !done_q && !cnt_en); // R8
endmodule

bind bist_cycle_counter bcc_checker #(.CNT_BITS(CNT_BITS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tap_state_i (tap_state_i),
  .cnt_sel_i   (cnt_sel_i),
  .tdo_o       (tdo_o),
  .cnt_q       (cnt_q),
  .cnt_sh      (cnt_sh),
  .done_q      (done_q),
  .cnt_en      (cnt_en)
);

// File: tb/tb_bist_cycle_counter.sv
module tb_bist_cycle_counter;
  import bcc_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] st = TS_IDLE;
  logic on_i = 1'b0, off_i = 1'b0, csel = 1'b0, msel = 1'b0, tdi = 1'b0;
  logic tdo;

  logic p_on = 1'b0, p_off = 1'b0, p_csel = 1'b0, p_msel = 1'b0;

  int checks = 0;
  int errs = 0;
  logic tdo_s;

  // reference model state
  logic [31:0] m_cnt, m_shc;
  logic [7:0]  m_shm;
  logic [6:0]  m_mode;
  logic        m_done, m_en;

  always #4 clk = ~clk;

  bist_cycle_counter dut (
    .clk_i(clk), .rst_ni(rst_ni), .tap_state_i(st),
    .cnt_on_i(on_i), .cnt_off_i(off_i), .cnt_sel_i(csel), .mode_sel_i(msel),
    .tdi_i(tdi), .tdo_o(tdo)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_shc = '0; m_shm = 8'h01; m_mode = 7'h01; m_done = 1'b0; m_en = 1'b0;
  endtask

  task automatic step(input logic [3:0] s, input logic b);
    logic [31:0] n_cnt;
    logic n_done;
    @(posedge clk); #1;
    st = s; tdi = b; on_i = p_on; off_i = p_off; csel = p_csel; msel = p_msel;
    @(negedge clk); #1;
    tdo_s = tdo;
    if (s != TS_SHIFT_DR) chk("R7 tdo quiet", {31'b0, tdo_s}, 32'd0);
    if (s == TS_RESET) begin
      model_reset();
    end else begin
      n_cnt = m_cnt; n_done = m_done;
      if (s == TS_UPDATE_DR && csel) begin
        n_cnt = m_shc; n_done = (m_shc == 0);
      end else if (m_en && m_cnt != 0) begin
        n_cnt = m_cnt - 1;
        if (m_cnt == 1) n_done = 1'b1;
      end
      if (s == TS_UPDATE_DR && msel) m_mode = m_shm[6:0];
      if (s == TS_CAPTURE_DR && csel) m_shc = m_cnt;
      else if (s == TS_SHIFT_DR && csel) m_shc = {b, m_shc[31:1]};
      if (s == TS_CAPTURE_DR && msel) m_shm = {m_done, m_mode};
      else if (s == TS_SHIFT_DR && msel) m_shm = {b, m_shm[7:1]};
      if (off_i) m_en = 1'b0;
      else if (on_i) m_en = 1'b1;
      m_cnt = n_cnt; m_done = n_done;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(TS_IDLE, 1'b0);
  endtask

  // capture, shift width bits out while shifting wdata in, update
  task automatic read_dr(input logic is_cnt, input logic [31:0] wdata,
                         input logic [31:0] exp, input string tag);
    int w;
    logic [31:0] got;
    w = is_cnt ? 32 : 8;
    got = '0;
    p_csel = is_cnt; p_msel = !is_cnt;
    step(TS_CAPTURE_DR, 1'b0);
    for (int i = 0; i < w; i++) begin
      step(TS_SHIFT_DR, wdata[i]);
      got[i] = tdo_s;
    end
    step(TS_EXIT1_DR, 1'b0);
    step(TS_UPDATE_DR, 1'b0);
    p_csel = 1'b0; p_msel = 1'b0;
    step(TS_IDLE, 1'b0);
    chk(tag, got, exp);
  endtask

  task automatic read_cnt(input logic [31:0] wdata, input string tag);
    read_dr(1'b1, wdata, m_cnt, tag);
  endtask

  task automatic read_mode(input logic [7:0] wdata, input string tag);
    read_dr(1'b0, {24'b0, wdata}, {24'b0, m_done, m_mode}, tag);
  endtask

  task automatic pulse_on();  p_on = 1'b1;  step(TS_IDLE, 1'b0); p_on = 1'b0;  endtask
  task automatic pulse_off(); p_off = 1'b1; step(TS_IDLE, 1'b0); p_off = 1'b0; endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h0BCC_2024));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 tdo after reset", {31'b0, tdo}, 32'd0);

    read_mode(8'h01, "R1 mode reset value");
    read_cnt(32'd5, "R1 count reset zero");      // loads 5, done cleared
    idle(4);
    read_cnt(32'd3, "R4 count held while off");  // still 5, loads 3
    read_mode(8'h01, "R5 done low before terminal");
    pulse_on();
    idle(1);
    read_cnt(32'h0000_0002, "R3 count after decrement");
    read_mode(8'h5A, "R5 done after terminal");
    read_mode(8'h33, "R6 mode bits written, done sticky");
    read_cnt(32'd40, "R3 held at zero");
    read_mode(8'h80, "R5 done cleared by nonzero load");
    pulse_off();
    idle(3);
    read_cnt(32'd0, "R4 frozen after off");
    read_mode(8'h01, "R5 zero load sets done");
    read_cnt(32'hA5C3_0F96, "R2 shift lsb first");
    read_cnt(32'd7, "R2 wide value readback");
    pulse_on();
    step(TS_RESET, 1'b0);
    step(TS_RESET, 1'b0);
    idle(2);
    read_mode(8'h7F, "R8 mode after test-logic-reset");
    read_cnt(32'd9, "R8 count after test-logic-reset");
    idle(5);
    read_cnt(32'd1, "R8 enable cleared by reset");

    for (int it = 0; it < 60; it++) begin
      int op;
      logic [31:0] v;
      op = int'($urandom_range(0, 9));
      v = ($urandom_range(0, 7) == 0) ? $urandom() : 32'($urandom_range(0, 45));
      case (op)
        0, 1, 2: read_cnt(v, "R3 random count readback");
        3, 4:    read_mode(8'($urandom()), "R5 random done poll");
        5:       pulse_on();
        6:       pulse_off();
        7:       begin p_on = 1'b1; p_off = 1'b1; step(TS_IDLE, 1'b0); p_on = 1'b0; p_off = 1'b0;
                       read_cnt(v, "R4 off dominates on"); end
        8:       if ($urandom_range(0, 3) == 0) begin
                   step(TS_RESET, 1'b0);
                   read_mode(8'($urandom()), "R8 random reset mode");
                 end
        default: ;
      endcase
      idle(int'($urandom_range(0, 20)));
    end
    read_mode(8'h01, "R5 final poll");
    read_cnt(32'd0, "R3 final count");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule